// File: doc/BRIEF.md
# Programmable Watchdog Timer with Selectable Period Format

This block is a watchdog countdown timer that software controls through a small single-cycle register port. Once started, it counts down in millisecond steps. A millisecond step is a fixed number of system clock cycles. If software does not refresh the timer before the count runs out, the block reports expiry. A build-time parameter chooses the period encoding. In the exponent format, the period field `n` gives a period of 2^n ms. In the seconds format, the field gives whole seconds, and a readable register shows how many seconds remain. A second parameter chooses what expiry does. In reset mode, expiry drives a reset request level and sets a sticky cause flag that survives the system reset. In alarm mode, expiry produces a single-cycle alarm pulse.

The control logic is a three-state machine. The states are `ST_IDLE` (stopped), `ST_RUN` (counting) and `ST_FIRED` (expired, counter frozen). The transitions are:
- ARM, from `ST_IDLE` to `ST_RUN`: writing 1 to the enable bit loads the full period.
- REFRESH, from `ST_RUN` to `ST_RUN`: a kick write reloads the full period.
- HALT, from `ST_RUN` to `ST_IDLE`: writing 0 to the enable bit stops the count.
- EXPIRE, from `ST_RUN` to `ST_FIRED`: the last millisecond of the period elapses.
- DISARM, from `ST_FIRED` to `ST_IDLE`: writing 0 to the enable bit.

Power-on reset (`por_n`) and system reset (`sys_rst_n`) both return the machine to `ST_IDLE`. Only power-on reset clears the cause flag.

Register offsets on `bus_addr` are as follows. Bit 0 of each register carries the single-bit fields.
- 0: control. Bit 0 enables the timer. Other bits read 0 and are ignored on write.
- 1: kick. Writing 1 to bit 0 refreshes the timer. This register reads 0.
- 2: period.
- 3: seconds remaining.
- 4: cause. Bit 0 is the sticky flag, and writing 1 to it clears it.

Other offsets read 0.

Top module: `wdt_core`

## Requirements
- R1: After power-on reset, the block behaves as follows. Both outputs are 0. The control register reads 0. The cause register reads 0. The remaining-seconds register reads 0. The period register reads its minimum: 10 in exponent format, 1 in seconds format.
- R2: An ARM write at clock edge E causes expiry to be reported at edge E + N*CLK_PER_MS. N is 2^n ms in exponent format, or P*1000 ms in seconds format. The output stays low at every edge before that.
- R3: The period register stores the written byte clamped as follows. In exponent format the byte is clamped to the range 10 to MAX_EXP (default 15), which gives a minimum of about 1 s and a maximum of about 32 s. In seconds format the byte is stored as written, except that 0 is stored as 1.
- R4: Writing 1 to kick bit 0 while running reloads the full period, so expiry moves to the kick edge plus N*CLK_PER_MS. A kick write with bit 0 clear has no effect. The kick register reads 0.
- R5: Writing 0 to the enable bit while running stops the countdown, so no expiry follows. A later ARM write starts a full new period.
- R6: A period write while running does not change the countdown in progress. The new value takes effect at the next ARM write.
- R7: In seconds format, the remaining-seconds register reads P right after ARM and drops by one each 1000 ms. It reads 0 after expiry. In exponent format it always reads 0.
- R8: In reset mode, expiry raises `wd_reset_o` and holds it until a system reset or a DISARM write. `wd_alarm_o` stays 0 in this mode.
- R9: In alarm mode, expiry raises `wd_alarm_o` for exactly one cycle. `wd_reset_o` and the cause flag stay 0 in this mode.
- R10: After expiry the counter is frozen and the control register still reads 1. The block leaves `ST_FIRED` only through DISARM or a reset.
- R11: In reset mode, expiry sets the cause flag. The flag survives `sys_rst_n` and is cleared by `por_n` or by writing 1 to cause bit 0. Writing 0 to cause bit 0 leaves the flag unchanged.
- R12: A control write changes only the enable bit, and the control register reads back 1 while running. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| sys_rst_n | input | 1 | System reset, active low, asynchronous; clears all but the cause flag |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| wd_reset_o | output | 1 | Reset request level (reset mode) |
| wd_alarm_o | output | 1 | One-cycle alarm pulse (alarm mode) |

## Verification
Read data is combinational, so register checks sample it shortly after the address settles at a falling edge. The effect of a write is visible from the falling edge that follows the write's sampling edge. Expiry is registered, so it appears right after edge E + N*CLK_PER_MS, where E is the edge that sampled the ARM or kick write. The bench records E from a free-running edge counter. It checks that the output is low at the falling edge after E + N*CLK_PER_MS - 1 and high at the falling edge after E + N*CLK_PER_MS. Remaining seconds change right after edges E + k*1000*CLK_PER_MS, and the bench samples each side of such an edge.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
    localparam int WDT_AW = 3;
    localparam int WDT_DW = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FIRED = 2'd2
    } wdt_state_e;

    localparam logic [WDT_AW-1:0] OFS_CTRL   = 3'd0;
    localparam logic [WDT_AW-1:0] OFS_KICK   = 3'd1;
    localparam logic [WDT_AW-1:0] OFS_PERIOD = 3'd2;
    localparam logic [WDT_AW-1:0] OFS_REMAIN = 3'd3;
    localparam logic [WDT_AW-1:0] OFS_CAUSE  = 3'd4;
endpackage

// File: rtl/wdt_tick.sv
`timescale 1ns/1ps
// Millisecond prescaler: one tick every CLK_PER_MS cycles while running.
module wdt_tick #(
    parameter int CLK_PER_MS = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_MS - 1);

    logic [PW-1:0] pre_q;
    logic          wrap;

    assign wrap = (pre_q == PRE_LAST);
    assign tick = run && !restart && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (restart) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= wrap ? '0 : pre_q + 1'b1;
        end
    end

    // R2: a tick is always followed by a restarted prescale phase
    p_tick_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pre_q == '0));
endmodule

// File: rtl/wdt_countdown.sv
`timescale 1ns/1ps
// Period counter; FMT_SECONDS picks the exponent or seconds variant.
module wdt_countdown #(
    parameter int FMT_SECONDS = 0,
    parameter int MS_PER_SEC  = 1000,
    parameter int MAX_EXP     = 15,
    parameter int FIELD_W     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               tick,
    input  logic [FIELD_W-1:0] period,
    output logic               done,
    output logic [7:0]         secs_left
);
    // R3: the machine never loads an empty period
    p_period_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (period != '0));

    generate
        if (FMT_SECONDS != 0) begin : g_sec
            localparam int MW = $clog2(MS_PER_SEC);
            localparam logic [MW-1:0] MS_LAST = MW'(MS_PER_SEC - 1);

            logic [MW-1:0] ms_q;
            logic [7:0]    sec_q;
            logic          ms_zero;

            assign ms_zero   = (ms_q == '0);
            assign done      = tick && ms_zero && (sec_q == 8'd1);
            assign secs_left = sec_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ms_q  <= '0;
                    sec_q <= '0;
                end else if (load) begin
                    ms_q  <= MS_LAST;
                    sec_q <= period[7:0];
                end else if (tick) begin
                    if (ms_zero) begin
                        ms_q <= MS_LAST;
                        if (sec_q != 8'd0) sec_q <= sec_q - 8'd1;
                    end else begin
                        ms_q <= ms_q - 1'b1;
                    end
                end
            end

            // R7: remaining seconds only rise on a load
            p_secs_monotonic_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !load |=> (sec_q <= $past(sec_q)));
        end else begin : g_exp
            localparam int CW = MAX_EXP + 1;

            logic [CW-1:0] cnt_q;

            assign done      = tick && (cnt_q == CW'(1));
            assign secs_left = 8'd0;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (load) begin
                    cnt_q <= CW'(1) << period;
                end else if (tick && (cnt_q != '0)) begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end

            // R2: a load always leaves a non-empty count
            p_load_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
                load |=> (cnt_q != '0));
        end
    endgenerate
endmodule

// File: rtl/wdt_core.sv
`timescale 1ns/1ps
module wdt_core #(
    parameter int FMT_SECONDS = 0,
    parameter int RESET_MODE  = 1,
    parameter int CLK_PER_MS  = 250000,
    parameter int MS_PER_SEC  = 1000,
    parameter int MAX_EXP     = 15
) (
    input  logic                       clk,
    input  logic                       por_n,
    input  logic                       sys_rst_n,
    input  logic                       bus_wr,
    input  logic [wdt_pkg::WDT_AW-1:0] bus_addr,
    input  logic [wdt_pkg::WDT_DW-1:0] bus_wdata,
    output logic [wdt_pkg::WDT_DW-1:0] bus_rdata,
    output logic                       wd_reset_o,
    output logic                       wd_alarm_o
);
    import wdt_pkg::*;

    localparam int DW      = WDT_DW;
    localparam int MIN_EXP = $clog2(MS_PER_SEC);
    localparam int EXP_W   = $clog2(MAX_EXP + 1);
    localparam int FIELD_W = (FMT_SECONDS != 0) ? DW : EXP_W;
    localparam logic [FIELD_W-1:0] PERIOD_RST =
        FIELD_W'((FMT_SECONDS != 0) ? 1 : MIN_EXP);

    logic       core_rst_n;
    logic       wr_ctrl, wr_kick, wr_period, wr_cause;
    logic       load, tick, done;
    logic [7:0] secs_left;
    logic [FIELD_W-1:0] period_q;
    logic       cause_q;
    logic       rst_q, alarm_q;
    wdt_state_e state_q, state_d;

    assign core_rst_n = por_n & sys_rst_n;
    assign wr_ctrl    = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_kick    = bus_wr && (bus_addr == OFS_KICK);
    assign wr_period  = bus_wr && (bus_addr == OFS_PERIOD);
    assign wr_cause   = bus_wr && (bus_addr == OFS_CAUSE);

    function automatic logic [FIELD_W-1:0] clamp_field(input logic [DW-1:0] d);
        int unsigned v;
        v = {{(32-DW){1'b0}}, d};
        if (FMT_SECONDS != 0) begin
            if (v == 0) v = 1;
        end else begin
            if (v < MIN_EXP)      v = MIN_EXP;
            else if (v > MAX_EXP) v = MAX_EXP;
        end
        return v[FIELD_W-1:0];
    endfunction

    // Period field: written any time, used at the next load.
    always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n)    period_q <= PERIOD_RST;
        else if (wr_period) period_q <= clamp_field(bus_wdata);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_ctrl && bus_wdata[0]) begin
                    state_d = ST_RUN;
                    load    = 1'b1;
                end
            end
            ST_RUN: begin
                if (wr_ctrl && !bus_wdata[0])  state_d = ST_IDLE;
                else if (wr_kick && bus_wdata[0]) load = 1'b1;
                else if (done)                 state_d = ST_FIRED;
            end
            ST_FIRED: begin
                if (wr_ctrl && !bus_wdata[0]) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n) state_q <= ST_IDLE;
        else             state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n) begin
            rst_q   <= 1'b0;
            alarm_q <= 1'b0;
        end else begin
            rst_q   <= (RESET_MODE != 0) && (state_d == ST_FIRED);
            alarm_q <= (RESET_MODE == 0) && (state_q == ST_RUN) && (state_d == ST_FIRED);
        end
    end

    assign wd_reset_o = rst_q;
    assign wd_alarm_o = alarm_q;

    // Cause flag: only power-on reset clears it
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cause_q <= 1'b0;
        end else if ((RESET_MODE != 0) && (state_q == ST_RUN) && (state_d == ST_FIRED)) begin
            cause_q <= 1'b1;
        end else if (wr_cause && bus_wdata[0]) begin
            cause_q <= 1'b0;
        end
    end

    // Read mux
    always_comb begin
        case (bus_addr)
            OFS_CTRL:   bus_rdata = {{(DW-1){1'b0}}, (state_q != ST_IDLE)};
            OFS_PERIOD: bus_rdata = DW'(period_q);
            OFS_REMAIN: bus_rdata = secs_left;
            OFS_CAUSE:  bus_rdata = {{(DW-1){1'b0}}, cause_q};
            default:    bus_rdata = '0;
        endcase
    end

    wdt_tick #(.CLK_PER_MS(CLK_PER_MS)) tick_i (
        .clk     (clk),
        .rst_n   (core_rst_n),
        .run     (state_q == ST_RUN),
        .restart (load),
        .tick    (tick)
    );

    wdt_countdown #(
        .FMT_SECONDS (FMT_SECONDS),
        .MS_PER_SEC  (MS_PER_SEC),
        .MAX_EXP     (MAX_EXP),
        .FIELD_W     (FIELD_W)
    ) count_i (
        .clk       (clk),
        .rst_n     (core_rst_n),
        .load      (load),
        .tick      (tick),
        .period    (period_q),
        .done      (done),
        .secs_left (secs_left)
    );

    // R9: alarm is a single-cycle pulse
    p_alarm_single_r9: assert property (@(posedge clk) disable iff (!core_rst_n)
        wd_alarm_o |=> !wd_alarm_o);

    // R8: reset request holds until DISARM or reset
    p_reset_level_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
        (wd_reset_o && !(wr_ctrl && !bus_wdata[0])) |=> wd_reset_o);

    // R8: the two expiry outputs never coincide
    p_outputs_exclusive_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
        wd_reset_o |-> !wd_alarm_o);

    // R11: cause flag stays set unless cleared by write or power-on
    p_cause_sticky_r11: assert property (@(posedge clk) disable iff (!por_n)
        (cause_q && !(wr_cause && bus_wdata[0])) |=> cause_q);
endmodule

// File: tb/wdt_core_tb_top.sv
`timescale 1ns/1ps
module wdt_core_tb_top;
    localparam int CPM = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic por_n, sys_rst_n;
    logic e_wr, s_wr;
    logic [2:0] e_addr, s_addr;
    logic [7:0] e_wdata, s_wdata, e_rdata, s_rdata;
    logic e_rst, e_alm, s_rst, s_alm;

    int n_chk = 0;
    int n_fail = 0;

    wdt_core #(.FMT_SECONDS(0), .RESET_MODE(1), .CLK_PER_MS(CPM)) dut_i (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .bus_wr(e_wr), .bus_addr(e_addr), .bus_wdata(e_wdata), .bus_rdata(e_rdata),
        .wd_reset_o(e_rst), .wd_alarm_o(e_alm));

    wdt_core #(.FMT_SECONDS(1), .RESET_MODE(0), .CLK_PER_MS(CPM)) dut_s_i (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .bus_wr(s_wr), .bus_addr(s_addr), .bus_wdata(s_wdata), .bus_rdata(s_rdata),
        .wd_reset_o(s_rst), .wd_alarm_o(s_alm));

    function automatic int exp_clamp(input int d);
        if (d < 10) return 10;
        if (d > 15) return 15;
        return d;
    endfunction

    function automatic int sec_clamp(input int d);
        return (d == 0) ? 1 : d;
    endfunction

    function automatic int exp_cycles(input int n);
        return (1 << n) * CPM;
    endfunction

    function automatic int sec_cycles(input int p);
        return p * 1000 * CPM;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic wr(input bit sec, input logic [2:0] a, input logic [7:0] d,
                      output int unsigned edge_at);
        @(negedge clk);
        if (sec) begin s_wr = 1'b1; s_addr = a; s_wdata = d; end
        else     begin e_wr = 1'b1; e_addr = a; e_wdata = d; end
        @(negedge clk);
        s_wr = 1'b0;
        e_wr = 1'b0;
        edge_at = cyc;
    endtask

    task automatic rd(input bit sec, input logic [2:0] a, output int v);
        if (sec) s_addr = a; else e_addr = a;
        #1;
        v = sec ? int'(s_rdata) : int'(e_rdata);
    endtask

    task automatic wait_to(input int unsigned t);
        while (cyc < t) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int unsigned te, t0;
        int v;
        void'($urandom(32'd5150));
        por_n = 0; sys_rst_n = 0;
        e_wr = 0; s_wr = 0; e_addr = 0; s_addr = 0; e_wdata = 0; s_wdata = 0;
        repeat (4) @(negedge clk);
        por_n = 1; sys_rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check("R1 e_rst", int'(e_rst), 0);
        check("R1 s_alm", int'(s_alm), 0);
        rd(0, 3'd0, v); check("R1 ctrl", v, 0);
        rd(0, 3'd2, v); check("R1 exp period", v, 10);
        rd(1, 3'd2, v); check("R1 sec period", v, 1);
        rd(0, 3'd4, v); check("R1 cause", v, 0);
        rd(1, 3'd3, v); check("R1 remain", v, 0);

        // R12 control other bits, unmapped offsets, R4 kick reads 0
        wr(0, 3'd0, 8'hFE, te);
        rd(0, 3'd0, v); check("R12 ctrl only bit0", v, 0);
        for (int a = 5; a < 8; a++) begin
            rd(0, 3'(a), v); check("R12 unmapped", v, 0);
        end
        rd(0, 3'd1, v); check("R4 kick reads 0", v, 0);

        // R3 directed and random clamping
        wr(0, 3'd2, 8'd0, te);   rd(0, 3'd2, v); check("R3 exp 0", v, 10);
        wr(0, 3'd2, 8'd9, te);   rd(0, 3'd2, v); check("R3 exp 9", v, 10);
        wr(0, 3'd2, 8'd15, te);  rd(0, 3'd2, v); check("R3 exp 15", v, 15);
        wr(0, 3'd2, 8'hFF, te);  rd(0, 3'd2, v); check("R3 exp FF", v, 15);
        wr(1, 3'd2, 8'd0, te);   rd(1, 3'd2, v); check("R3 sec 0", v, 1);
        wr(1, 3'd2, 8'd255, te); rd(1, 3'd2, v); check("R3 sec 255", v, 255);
        for (int i = 0; i < 8; i++) begin
            int d;
            d = int'($urandom % 256);
            wr(0, 3'd2, 8'(d), te); rd(0, 3'd2, v); check("R3 exp rand", v, exp_clamp(d));
            wr(1, 3'd2, 8'(d), te); rd(1, 3'd2, v); check("R3 sec rand", v, sec_clamp(d));
        end

        // R2 / R8 / R10 / R11 in exponent reset mode
        wr(0, 3'd2, 8'd10, te);
        wr(0, 3'd0, 8'd1, t0);
        rd(0, 3'd0, v); check("R12 ctrl reads 1", v, 1);
        rd(0, 3'd3, v); check("R7 exp remain 0", v, 0);
        wait_to(t0 + exp_cycles(10) - 1);
        check("R2 before expiry", int'(e_rst), 0);
        wait_to(t0 + exp_cycles(10));
        check("R2 at expiry", int'(e_rst), 1);
        check("R8 no alarm", int'(e_alm), 0);
        repeat (30) @(negedge clk);
        check("R8 held", int'(e_rst), 1);
        rd(0, 3'd0, v); check("R10 ctrl still 1", v, 1);
        rd(0, 3'd4, v); check("R11 cause set", v, 1);
        @(negedge clk); sys_rst_n = 0; @(negedge clk); sys_rst_n = 1;
        check("R8 cleared by sys reset", int'(e_rst), 0);
        rd(0, 3'd4, v); check("R11 survives sys reset", v, 1);
        rd(0, 3'd0, v); check("R11 ctrl after sys reset", v, 0);
        wr(0, 3'd4, 8'd0, te); rd(0, 3'd4, v); check("R11 write 0 keeps", v, 1);
        wr(0, 3'd4, 8'd1, te); rd(0, 3'd4, v); check("R11 write 1 clears", v, 0);

        // R4 kick with bit0 clear is ignored; R10 disarm from fired
        wr(0, 3'd0, 8'd1, t0);
        wait_to(t0 + 500);
        wr(0, 3'd1, 8'd0, te);
        wait_to(t0 + exp_cycles(10) - 1);
        check("R4 kick0 before", int'(e_rst), 0);
        wait_to(t0 + exp_cycles(10));
        check("R4 kick0 no effect", int'(e_rst), 1);
        wr(0, 3'd0, 8'd0, te);
        check("R10 disarm clears", int'(e_rst), 0);
        rd(0, 3'd0, v); check("R10 ctrl idle", v, 0);

        // R4 random kicks
        for (int i = 0; i < 3; i++) begin
            int unsigned tk;
            wr(0, 3'd0, 8'd1, t0);
            wait_to(t0 + 200 + ($urandom % 1300));
            wr(0, 3'd1, 8'd1, tk);
            wait_to(t0 + exp_cycles(10));
            check("R4 original deadline passed", int'(e_rst), 0);
            wait_to(tk + exp_cycles(10) - 1);
            check("R4 before new deadline", int'(e_rst), 0);
            wait_to(tk + exp_cycles(10));
            check("R4 at new deadline", int'(e_rst), 1);
            wr(0, 3'd0, 8'd0, te);
        end

        // R5 stop and restart
        wr(0, 3'd0, 8'd1, t0);
        wait_to(t0 + 1000);
        wr(0, 3'd0, 8'd0, te);
        wait_to(t0 + exp_cycles(10) + 1000);
        check("R5 stopped", int'(e_rst), 0);
        wr(0, 3'd0, 8'd1, t0);
        wait_to(t0 + exp_cycles(10) - 1);
        check("R5 restart before", int'(e_rst), 0);
        wait_to(t0 + exp_cycles(10));
        check("R5 restart full period", int'(e_rst), 1);
        wr(0, 3'd0, 8'd0, te);
        wr(0, 3'd4, 8'd1, te);

        // R6 / R7 / R9 / R10 seconds alarm mode
        wr(1, 3'd2, 8'd2, te);
        wr(1, 3'd0, 8'd1, t0);
        rd(1, 3'd3, v); check("R7 remain at arm", v, 2);
        wait_to(t0 + 100);
        wr(1, 3'd2, 8'd3, te);
        rd(1, 3'd3, v); check("R6 remain unchanged", v, 2);
        wait_to(t0 + 1000 * CPM - 1);
        rd(1, 3'd3, v); check("R7 before 1 s", v, 2);
        wait_to(t0 + 1000 * CPM);
        rd(1, 3'd3, v); check("R7 after 1 s", v, 1);
        wait_to(t0 + sec_cycles(2) - 1);
        check("R6 old period before", int'(s_alm), 0);
        wait_to(t0 + sec_cycles(2));
        check("R9 alarm pulse", int'(s_alm), 1);
        check("R9 no reset", int'(s_rst), 0);
        @(negedge clk);
        check("R9 pulse one cycle", int'(s_alm), 0);
        repeat (50) @(negedge clk);
        check("R10 no repeat alarm", int'(s_alm), 0);
        rd(1, 3'd0, v); check("R10 sec ctrl 1", v, 1);
        rd(1, 3'd3, v); check("R7 remain 0 after", v, 0);
        rd(1, 3'd4, v); check("R9 no cause", v, 0);
        wr(1, 3'd0, 8'd0, te);
        wr(1, 3'd0, 8'd1, t0);
        rd(1, 3'd3, v); check("R6 new period loaded", v, 3);
        wait_to(t0 + sec_cycles(3) - 1);
        check("R6 new before", int'(s_alm), 0);
        wait_to(t0 + sec_cycles(3));
        check("R6 new period expiry", int'(s_alm), 1);
        wr(1, 3'd0, 8'd0, te);

        // R2 random periods
        for (int i = 0; i < 2; i++) begin
            int p;
            p = 1 + int'($urandom % 2);
            wr(1, 3'd2, 8'(p), te);
            wr(1, 3'd0, 8'd1, t0);
            wait_to(t0 + sec_cycles(p) - 1);
            check("R2 sec rand before", int'(s_alm), 0);
            wait_to(t0 + sec_cycles(p));
            check("R2 sec rand at", int'(s_alm), 1);
            wr(1, 3'd0, 8'd0, te);
        end
        for (int i = 0; i < 2; i++) begin
            int n;
            n = 10 + int'($urandom % 2);
            wr(0, 3'd2, 8'(n), te);
            wr(0, 3'd0, 8'd1, t0);
            wait_to(t0 + exp_cycles(n) - 1);
            check("R2 exp rand before", int'(e_rst), 0);
            wait_to(t0 + exp_cycles(n));
            check("R2 exp rand at", int'(e_rst), 1);
            if (i == 0) wr(0, 3'd0, 8'd0, te);
        end

        // R11 power-on reset clears the cause flag
        rd(0, 3'd4, v); check("R11 cause before por", v, 1);
        @(negedge clk); por_n = 0; @(negedge clk); por_n = 1;
        rd(0, 3'd4, v); check("R11 cleared by por", v, 0);
        check("R1 output after por", int'(e_rst), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule